// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup with Translation Buffer

This block is the load lookup path of a small set-associative level-one data cache. The cache is indexed with virtual address bits and tagged with physical address bits. A load presents a virtual address. The set index comes only from bits inside the page offset, so it needs no translation. In the same cycle, the block does two things: it reads the tag, valid bit and line of every way in that set, and it looks up the virtual page number in a small set-associative translation buffer. The physical tag formed from the translated page number is then compared with every fetched tag at once. A match returns the addressed 32-bit word. No match reports a cache miss.

When the translation buffer misses, the fetched set is discarded and the request is parked. Ready is held low and a translation request goes out with the page number. When the second-level source returns a physical page number, two things happen in the same cycle. The number is written into the translation buffer, with round-robin replacement inside its set. It is also forwarded straight into the tag compare of the parked access, so the replay does not need a second buffer lookup. A separate fill port installs a line and its physical tag into the way chosen by a bit-per-way pseudo-LRU policy. The same policy also tracks cache hits.

With the default parameters, the block has a 32-bit virtual address, a 32-bit physical address, 4 KiB pages and 64-byte lines. The cache has 64 sets of 4 ways. The translation buffer has 64 entries in 4 ways. Index and line offset together must fit inside the page offset.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, resp_valid_o and tlb_miss_o are 0 and req_ready_o is 1. The translation buffer and the cache hold no valid entries.
- R2: A request accepted on a translation-buffer hit produces resp_valid_o exactly one cycle later. In that response, resp_paddr_o = {translated page number, vaddr[11:0]} and tlb_miss_o stays 0.
- R3: When a valid way of set vaddr[11:6] holds physical tag paddr[31:12], resp_hit_o is 1. resp_data_o is then word vaddr[5:2] of that line, where word i occupies line bits [32i+31:32i].
- R4: When no valid way of the set matches the physical tag, resp_hit_o is 0 and resp_data_o is 0.
- R5: On a translation-buffer miss, the block gives no response for that request. From the next cycle until the refill, tlb_miss_o is 1, tlb_miss_vpn_o holds vaddr[31:12] unchanged, and req_ready_o is 0.
- R6: refill_valid_i while tlb_miss_o is 1 produces a response one cycle later. That response uses refill_ppn_i as the translation, and in the same cycle tlb_miss_o falls and req_ready_o returns to 1. The entry is kept, so the next access to that page hits the translation buffer.
- R7: The translation buffer has 16 sets selected by vpn[3:0], with 4 ways each. Refills replace ways round-robin within a set, so the fifth distinct page of a set evicts the first one written.
- R8: A fill goes into the lowest-numbered way of its set whose recently-used bit is 0. Fills and cache hits set that way's bit. When all bits of the set would be 1, only the newly touched way keeps its bit.
- R9: Two virtual pages translated to the same physical page read the same cache line, with no duplicate copy.
- R10: While fill_valid_i is 1, req_ready_o is 0. A fill is presented only when no translation miss is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual address of the load |
| resp_valid_o | output | 1 | Lookup result valid for one cycle |
| resp_hit_o | output | 1 | Cache hit |
| resp_paddr_o | output | 32 | Translated physical address |
| resp_data_o | output | 32 | Addressed word on a hit, zero on a miss |
| tlb_miss_o | output | 1 | Translation request to the second-level source |
| tlb_miss_vpn_o | output | 20 | Page number that needs translating |
| refill_valid_i | input | 1 | Translation returned |
| refill_ppn_i | input | 20 | Returned physical page number |
| fill_valid_i | input | 1 | Line fill strobe |
| fill_line_addr_i | input | 26 | Physical line address of the fill (paddr[31:6]) |
| fill_line_i | input | 512 | Line data to install |

## Verification
The checker takes it as given that refill_valid_i rises only while a translation miss is pending. It also assumes that fill_valid_i is never raised while a miss is parked, so a fill never meets a replay in the same cycle. The bench keeps to these rules because its access task is the only place that drives a refill, and only after it has seen tlb_miss_o high. Fills are issued only between completed accesses. Under those conditions, the properties cover several things: the handshake blocking, the hold of the parked page number, the one-cycle replay after a refill, and the fact that every response traces back to an acceptance or a refill. The bench sweeps all 64 sets and all 16 word positions and checks the data against arithmetic line contents.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic {
        LK_IDLE      = 1'b0,
        LK_WAIT_XLAT = 1'b1
    } lk_state_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int SETS  = 16,
    parameter int WAYS  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o,
    input  logic             wr_en_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [PPN_W-1:0] wr_ppn_i
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn;
        logic [SETS-1:0][WAY_W-1:0]            rr;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic [SET_W-1:0] lk_set, wr_set;
    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic [WAYS-1:0]  match;

    assign lk_set = lk_vpn_i[SET_W-1:0];
    assign lk_tag = lk_vpn_i[VPN_W-1:SET_W];
    assign wr_set = wr_vpn_i[SET_W-1:0];
    assign wr_tag = wr_vpn_i[VPN_W-1:SET_W];

    // one comparator per way, gated by the entry's valid bit
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = st_q.vld[lk_set][w] && (st_q.tag[lk_set][w] == lk_tag);
    end

    always_comb begin
        lk_hit_o = |match;
        lk_ppn_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) lk_ppn_o = lk_ppn_o | st_q.ppn[lk_set][w];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.vld[wr_set][st_q.rr[wr_set]] = 1'b1;
            st_d.tag[wr_set][st_q.rr[wr_set]] = wr_tag;
            st_d.ppn[wr_set][st_q.rr[wr_set]] = wr_ppn_i;
            st_d.rr[wr_set] = (st_q.rr[wr_set] == WAY_W'(WAYS - 1)) ? '0 : st_q.rr[wr_set] + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 512
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [$clog2(SETS)-1:0]           rd_set_i,
    output logic [WAYS-1:0]                   rd_vld_o,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tag_o,
    output logic [WAYS-1:0][LINE_W-1:0]       rd_line_o,
    input  logic                              wr_en_i,
    input  logic [$clog2(SETS)-1:0]           wr_set_i,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] wr_way_i,
    input  logic [TAG_W-1:0]                  wr_tag_i,
    input  logic [LINE_W-1:0]                 wr_line_i
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] vld;
    } store_st_t;

    store_st_t st_d, st_q;

    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [LINE_W-1:0] line_mem [SETS][WAYS];

    // every way of the selected set is read in the same cycle
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_vld_o[w]  = st_q.vld[rd_set_i][w];
        assign rd_tag_o[w]  = tag_mem[rd_set_i][w];
        assign rd_line_o[w] = line_mem[rd_set_i][w];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.vld[wr_set_i][wr_way_i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            tag_mem[wr_set_i][wr_way_i]  <= wr_tag_i;
            line_mem[wr_set_i][wr_way_i] <= wr_line_i;
        end
    end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    touch_en_i,
    input  logic [$clog2(SETS)-1:0] touch_set_i,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] touch_way_i,
    input  logic [$clog2(SETS)-1:0] vic_set_i,
    output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] vic_way_o
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] mru;
    } plru_st_t;

    plru_st_t st_d, st_q;
    logic [WAYS-1:0] nxt;

    // victim: lowest way whose recently-used bit is clear
    always_comb begin
        vic_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.mru[vic_set_i][w]) vic_way_o = WAY_W'(w);
        end
    end

    always_comb begin
        st_d = st_q;
        nxt  = st_q.mru[touch_set_i] | (WAYS'(1) << touch_way_i);
        if (&nxt) nxt = WAYS'(1) << touch_way_i;
        if (touch_en_i) st_d.mru[touch_set_i] = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int LINE_BYTES  = 64,
    parameter int CACHE_SETS  = 64,
    parameter int CACHE_WAYS  = 4,
    parameter int TLB_ENTRIES = 64,
    parameter int TLB_WAYS    = 4,
    parameter int WORD_W      = 32
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic                                    req_valid_i,
    output logic                                    req_ready_o,
    input  logic [VA_W-1:0]                         req_vaddr_i,
    output logic                                    resp_valid_o,
    output logic                                    resp_hit_o,
    output logic [PA_W-1:0]                         resp_paddr_o,
    output logic [WORD_W-1:0]                       resp_data_o,
    output logic                                    tlb_miss_o,
    output logic [VA_W-PAGE_BITS-1:0]               tlb_miss_vpn_o,
    input  logic                                    refill_valid_i,
    input  logic [PA_W-PAGE_BITS-1:0]               refill_ppn_i,
    input  logic                                    fill_valid_i,
    input  logic [PA_W-$clog2(LINE_BYTES)-1:0]      fill_line_addr_i,
    input  logic [LINE_BYTES*8-1:0]                 fill_line_i
);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(CACHE_SETS);
    localparam int IDX_HI   = OFF_W + IDX_W;        // must not exceed PAGE_BITS
    localparam int TAG_W    = PA_W - IDX_HI;
    localparam int VPN_W    = VA_W - PAGE_BITS;
    localparam int PPN_W    = PA_W - PAGE_BITS;
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int WB       = $clog2(WORD_W / 8);
    localparam int CWAY_W   = (CACHE_WAYS > 1) ? $clog2(CACHE_WAYS) : 1;
    localparam int TLB_SETS = TLB_ENTRIES / TLB_WAYS;

    typedef struct packed {
        lk_state_e         st;
        logic [VA_W-1:0]   va;
        logic              rvld;
        logic              rhit;
        logic [WORD_W-1:0] rdata;
        logic [PA_W-1:0]   rpa;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                                 waiting, accept, replay, fire;
    logic [VA_W-1:0]                      look_va;
    logic [IDX_W-1:0]                     look_set, fill_set;
    logic                                 tlb_hit;
    logic [PPN_W-1:0]                     tlb_ppn, xlat_ppn;
    logic [PA_W-1:0]                      look_pa;
    logic [TAG_W-1:0]                     look_tag;
    logic [CACHE_WAYS-1:0]                rd_vld, way_hit;
    logic [CACHE_WAYS-1:0][TAG_W-1:0]     rd_tag;
    logic [CACHE_WAYS-1:0][LINE_W-1:0]    rd_line;
    logic [LINE_W-1:0]                    hit_line;
    logic [CWAY_W-1:0]                    hit_way, vic_way, touch_way;
    logic [IDX_W-1:0]                     touch_set;
    logic                                 touch_en;

    assign waiting  = (ctl_q.st == LK_WAIT_XLAT);
    assign req_ready_o = !waiting && !fill_valid_i;
    assign accept   = req_valid_i && req_ready_o;
    assign replay   = waiting && refill_valid_i;

    // index from the untranslated page offset; parked address during replay
    assign look_va  = waiting ? ctl_q.va : req_vaddr_i;
    assign look_set = look_va[IDX_HI-1:OFF_W];
    assign xlat_ppn = waiting ? refill_ppn_i : tlb_ppn;
    assign look_pa  = {xlat_ppn, look_va[PAGE_BITS-1:0]};
    assign look_tag = look_pa[PA_W-1:IDX_HI];
    assign fire     = (accept && tlb_hit) || replay;
    assign fill_set = fill_line_addr_i[IDX_W-1:0];

    vipt_tlb #(
        .VPN_W (VPN_W),
        .PPN_W (PPN_W),
        .SETS  (TLB_SETS),
        .WAYS  (TLB_WAYS)
    ) i_tlb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lk_vpn_i (look_va[VA_W-1:PAGE_BITS]),
        .lk_hit_o (tlb_hit),
        .lk_ppn_o (tlb_ppn),
        .wr_en_i  (replay),
        .wr_vpn_i (ctl_q.va[VA_W-1:PAGE_BITS]),
        .wr_ppn_i (refill_ppn_i)
    );

    vipt_way_store #(
        .SETS   (CACHE_SETS),
        .WAYS   (CACHE_WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) i_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_set_i  (look_set),
        .rd_vld_o  (rd_vld),
        .rd_tag_o  (rd_tag),
        .rd_line_o (rd_line),
        .wr_en_i   (fill_valid_i),
        .wr_set_i  (fill_set),
        .wr_way_i  (vic_way),
        .wr_tag_i  (fill_line_addr_i[PA_W-OFF_W-1:IDX_W]),
        .wr_line_i (fill_line_i)
    );

    vipt_plru #(
        .SETS (CACHE_SETS),
        .WAYS (CACHE_WAYS)
    ) i_plru (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .touch_en_i  (touch_en),
        .touch_set_i (touch_set),
        .touch_way_i (touch_way),
        .vic_set_i   (fill_set),
        .vic_way_o   (vic_way)
    );

    // physical tag compare, one comparator per way
    for (genvar w = 0; w < CACHE_WAYS; w++) begin : g_way
        assign way_hit[w] = rd_vld[w] && (rd_tag[w] == look_tag);
    end

    always_comb begin
        hit_line = '0;
        hit_way  = '0;
        for (int w = 0; w < CACHE_WAYS; w++) begin
            if (way_hit[w]) begin
                hit_line = hit_line | rd_line[w];
                hit_way  = hit_way | CWAY_W'(w);
            end
        end
    end

    // fill has priority; it never meets a lookup in the same cycle
    always_comb begin
        touch_en  = fill_valid_i || (fire && |way_hit);
        touch_set = fill_valid_i ? fill_set : look_set;
        touch_way = fill_valid_i ? vic_way : hit_way;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = fire;
        if (fire) begin
            ctl_d.rhit  = |way_hit;
            ctl_d.rpa   = look_pa;
            ctl_d.rdata = (|way_hit)
                ? hit_line[int'(look_va[OFF_W-1:WB]) * WORD_W +: WORD_W] : '0;
        end
        if (accept && !tlb_hit) begin
            ctl_d.st = LK_WAIT_XLAT;
            ctl_d.va = req_vaddr_i;
        end
        if (replay) ctl_d.st = LK_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign resp_valid_o   = ctl_q.rvld;
    assign resp_hit_o     = ctl_q.rhit;
    assign resp_paddr_o   = ctl_q.rpa;
    assign resp_data_o    = ctl_q.rdata;
    assign tlb_miss_o     = waiting;
    assign tlb_miss_vpn_o = ctl_q.va[VA_W-1:PAGE_BITS];
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic             resp_valid_o,
    input logic             tlb_miss_o,
    input logic [VPN_W-1:0] tlb_miss_vpn_o,
    input logic             refill_valid_i,
    input logic             fill_valid_i
);
    assert_miss_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_miss_o |-> !req_ready_o);

    assert_miss_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tlb_miss_o && !refill_valid_i) |=> (tlb_miss_o && $stable(tlb_miss_vpn_o)));

    assert_miss_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tlb_miss_o) |-> !resp_valid_o);

    assert_replay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tlb_miss_o && refill_valid_i) |=> (resp_valid_o && !tlb_miss_o));

    assert_refill_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refill_valid_i |-> tlb_miss_o);

    assert_resp_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_valid_o |-> $past((req_valid_i && req_ready_o) || (tlb_miss_o && refill_valid_i)));

    assert_fill_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_valid_i |-> !req_ready_o);

    assert_fill_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_valid_i |-> !tlb_miss_o);
endmodule

bind vipt_lookup vipt_lookup_chk #(
    .VPN_W (VA_W - PAGE_BITS)
) i_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .resp_valid_o   (resp_valid_o),
    .tlb_miss_o     (tlb_miss_o),
    .tlb_miss_vpn_o (tlb_miss_vpn_o),
    .refill_valid_i (refill_valid_i),
    .fill_valid_i   (fill_valid_i)
);

// File: tb/test_vipt_lookup.sv
module test_vipt_lookup;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_vaddr = '0;
    logic         resp_valid, resp_hit;
    logic [31:0]  resp_paddr, resp_data;
    logic         tlb_miss;
    logic [19:0]  tlb_miss_vpn;
    logic         refill_valid = 1'b0;
    logic [19:0]  refill_ppn = '0;
    logic         fill_valid = 1'b0;
    logic [25:0]  fill_addr = '0;
    logic [511:0] fill_line = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vipt_lookup i_vipt_lookup (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .req_valid_i      (req_valid),
        .req_ready_o      (req_ready),
        .req_vaddr_i      (req_vaddr),
        .resp_valid_o     (resp_valid),
        .resp_hit_o       (resp_hit),
        .resp_paddr_o     (resp_paddr),
        .resp_data_o      (resp_data),
        .tlb_miss_o       (tlb_miss),
        .tlb_miss_vpn_o   (tlb_miss_vpn),
        .refill_valid_i   (refill_valid),
        .refill_ppn_i     (refill_ppn),
        .fill_valid_i     (fill_valid),
        .fill_line_addr_i (fill_addr),
        .fill_line_i      (fill_line)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [25:0] laddr, input int i);
        return laddr * 32'h9E37_79B1 + i * 32'h0100_0193 + 32'd1;
    endfunction

    function automatic logic [511:0] line_of(input logic [25:0] laddr);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = word_of(laddr, i);
        return l;
    endfunction

    function automatic logic [31:0] mk_va(input logic [19:0] vpn, input int set, input int w);
        return {vpn, set[5:0], w[3:0], 2'b00};
    endfunction

    task automatic do_fill(input logic [19:0] ppn, input int set);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = {ppn, set[5:0]};
        fill_line  = line_of({ppn, set[5:0]});
        #1;
        chk(req_ready == 1'b0, "R10", "ready during fill", 64'(req_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // one load; xlat_hit tells whether the buffer is expected to hold the page
    task automatic access(input logic [31:0] va, input bit xlat_hit,
                          input logic [19:0] ppn, input bit exp_hit, input string req);
        logic [31:0] pa;
        pa = {ppn, va[11:0]};
        @(negedge clk);
        chk(req_ready == 1'b1, req, "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (xlat_hit) begin
            chk(resp_valid == 1'b1, "R2", "response one cycle after accept", 64'(resp_valid), 64'd1);
            chk(tlb_miss == 1'b0, "R2", "no translation request", 64'(tlb_miss), 64'd0);
        end else begin
            chk(resp_valid == 1'b0, "R5", "no response on xlat miss", 64'(resp_valid), 64'd0);
            chk(tlb_miss == 1'b1, "R5", "translation request", 64'(tlb_miss), 64'd1);
            chk(tlb_miss_vpn == va[31:12], "R5", "miss page number", 64'(tlb_miss_vpn), 64'(va[31:12]));
            chk(req_ready == 1'b0, "R5", "ready low while pending", 64'(req_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
            chk(tlb_miss == 1'b1 && resp_valid == 1'b0, "R5", "miss held", 64'({tlb_miss, resp_valid}), 64'd2);
            refill_valid = 1'b1;
            refill_ppn   = ppn;
            @(posedge clk);
            @(negedge clk);
            refill_valid = 1'b0;
            chk(resp_valid == 1'b1, "R6", "response after refill", 64'(resp_valid), 64'd1);
            chk(tlb_miss == 1'b0 && req_ready == 1'b1, "R6", "ready returns",
                64'({tlb_miss, req_ready}), 64'd1);
        end
        chk(resp_paddr == pa, "R2", "translated address", 64'(resp_paddr), 64'(pa));
        chk(resp_hit == exp_hit, req, "hit flag", 64'(resp_hit), 64'(exp_hit));
        if (exp_hit)
            chk(resp_data == word_of(pa[31:6], int'(pa[5:2])), req, "hit data",
                64'(resp_data), 64'(word_of(pa[31:6], int'(pa[5:2]))));
        else
            chk(resp_data == 32'd0, "R4", "miss data", 64'(resp_data), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk(resp_valid == 1'b0, req, "response lasts one cycle", 64'(resp_valid), 64'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
        chk(tlb_miss == 1'b0, "R1", "tlb_miss after reset", 64'(tlb_miss), 64'd0);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);

        // R8: pseudo-LRU placement in set 9, pages 0x20001.. -> 0x80001..
        do_fill(20'h80001, 9);   // A -> way0
        do_fill(20'h80002, 9);   // B -> way1
        do_fill(20'h80003, 9);   // C -> way2
        do_fill(20'h80004, 9);   // D -> way3, bits collapse to {3}
        access(mk_va(20'h20002, 9, 3), 1'b0, 20'h80002, 1'b1, "R3");  // touch B -> {1,3}
        do_fill(20'h80005, 9);   // E -> way0 evicts A
        do_fill(20'h80006, 9);   // F -> way2 evicts C
        access(mk_va(20'h20001, 9, 0), 1'b0, 20'h80001, 1'b0, "R8");
        access(mk_va(20'h20003, 9, 5), 1'b0, 20'h80003, 1'b0, "R8");
        access(mk_va(20'h20004, 9, 7), 1'b0, 20'h80004, 1'b1, "R8");
        access(mk_va(20'h20005, 9, 15), 1'b0, 20'h80005, 1'b1, "R8");
        access(mk_va(20'h20006, 9, 1), 1'b0, 20'h80006, 1'b1, "R8");
        access(mk_va(20'h20002, 9, 2), 1'b1, 20'h80002, 1'b1, "R6");   // kept entry

        // R7: round-robin within translation set 0xA
        for (int k = 0; k < 5; k++)
            access(mk_va(20'h0000A + 20'(k * 16), 3, 0), 1'b0, 20'h40000 + 20'(k), 1'b0, "R7");
        access(mk_va(20'h0001A, 3, 0), 1'b1, 20'h40001, 1'b0, "R7");
        access(mk_va(20'h0002A, 3, 0), 1'b1, 20'h40002, 1'b0, "R7");
        access(mk_va(20'h0000A, 3, 0), 1'b0, 20'h40000, 1'b0, "R7");   // evicted first
        access(mk_va(20'h0001A, 3, 0), 1'b0, 20'h40001, 1'b0, "R7");   // evicted by refill

        // R3: sweep all sets and word positions on page 0x12345 -> 0x6789A
        for (int s = 0; s < 64; s++) do_fill(20'h6789A, s);
        for (int s = 0; s < 64; s++)
            access(mk_va(20'h12345, s, s % 16), s != 0, 20'h6789A, 1'b1, "R3");

        // R4: unfilled physical page misses in every tested set
        for (int s = 0; s < 8; s++)
            access(mk_va(20'h00777, s * 8, s), s != 0, 20'h0ABCD, 1'b0, "R4");

        // R9: a second virtual page on the same physical page
        for (int s = 0; s < 64; s++)
            access(mk_va(20'h54321, s, (63 - s) % 16), s != 0, 20'h6789A, 1'b1, "R9");

        summary();
        $finish;
    end
endmodule